// File: doc/BRIEF.md
# Manchester framed serial transmitter

The block sends whole messages over one serial wire using Manchester line coding. A message enters as a stream of bytes on a valid/ready interface, with a start-of-message flag on the first byte and an end-of-message flag on the last one. On the wire every message becomes a frame made of three parts: an alternating preamble byte, the payload bytes, and an all-ones end sentinel. Each bit is sent most significant bit first.

Every bit period is split into two equal halves. A one is sent low then high, and a zero is sent high then low, so the level always changes at mid-bit. The half-bit length comes from a prescaler that turns the system clock into a slower time base, followed by a count of time-base ticks. Both counts are parameters. The line rests low between frames. A busy output is high while a frame is on the wire, and a done output pulses when the frame ends.

The source must have the next byte ready when the current byte ends. If it does not, the block treats this as an underflow and closes the frame with the sentinel.

Top module: `manch_frame_tx`

## Requirements
- R1: Each bit is sent as two halves. A 1 is low in the first half and high in the second. A 0 is high in the first half and low in the second. The line therefore always changes level at mid-bit.
- R2: The bits of each byte go out most significant bit first.
- R3: Every frame starts with the preamble byte 0xAA (bits 1,0,1,0,1,0,1,0), followed by the first payload byte.
- R4: While idle, `in_ready` is high. A beat with `in_valid` and `in_sop` both high starts a frame, and that beat's byte is the first payload byte. During a frame, `in_ready` is high only in the last clock cycle of a payload byte whose end-of-message flag was not set. A beat that has `in_valid` high in that cycle is taken as the next payload byte.
- R5: After the payload byte that carried `in_eop`, the block sends the sentinel 0xFF and then ends the frame.
- R6: If `in_valid` is low in the cycle when `in_ready` is high mid-frame, the block sends the sentinel 0xFF right after the current byte and ends the frame.
- R7: `line_out` is low whenever `busy` is low. `busy` goes high in the clock cycle after the start beat is accepted. It falls, and the line returns low, exactly when the sentinel's final half ends.
- R8: `frame_done` is high for exactly one cycle, namely the first cycle after the sentinel's final half.
- R9: While idle, a beat that has `in_valid` high but `in_sop` low is consumed and dropped. It starts no frame: `busy` and `line_out` stay low.
- R10: Each half lasts exactly CLKS_PER_TICK × TICKS_PER_HALF clock cycles. The first half begins in the cycle after the start beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | DATA_W | Payload byte |
| in_valid | input | 1 | Payload byte is present |
| in_sop | input | 1 | Byte is the first of a message |
| in_eop | input | 1 | Byte is the last of a message |
| in_ready | output | 1 | Block takes the byte in this cycle |
| line_out | output | 1 | Manchester coded serial line |
| busy | output | 1 | A frame is on the wire |
| frame_done | output | 1 | One-cycle pulse when a frame ends |

## Verification
The bench checks the line level in the first and the last cycle of every half-bit, in frames of one to four bytes. A half that is one cycle short or long, or a swapped polarity, therefore shows up as a wrong level at the edge of a half. Payload bytes of 0xFF and 0x80 are included. These show whether the sentinel and the most-significant-bit ordering stay distinct from the data.

Some frames end through the end-of-message flag and others through a withheld byte. This shows whether an underflow closes the frame at once, rather than stalling it or sending stale data. It also shows whether an end-of-message byte wrongly pulses `in_ready`. Idle beats without the start flag must leave the line quiet. Each frame's done pulse must land on its exact cycle and last one cycle only, which exposes a pulse that is late, stretched or missing.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_PAY  = 2'd2,
    ST_SENT = 2'd3
  } mtx_state_e;

  // Alternating pattern that starts with a one in the most significant position.
  function automatic logic [63:0] alt_pattern(input int width);
    logic [63:0] p;
    p = '0;
    for (int i = 0; i < width; i++) begin
      p[i] = ((width - 1 - i) % 2) == 0;
    end
    return p;
  endfunction
endpackage

// File: rtl/mtx_tick_gen.sv
module mtx_tick_gen #(
  parameter int CLKS_PER_TICK  = 125,
  parameter int TICKS_PER_HALF = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic half_end
);
  localparam int PW       = (CLKS_PER_TICK  > 1) ? $clog2(CLKS_PER_TICK)  : 1;
  localparam int HW       = (TICKS_PER_HALF > 1) ? $clog2(TICKS_PER_HALF) : 1;
  localparam int HALF_LEN = CLKS_PER_TICK * TICKS_PER_HALF;

  logic [PW-1:0] pre_cnt;
  logic [HW-1:0] tick_cnt;
  logic          tick;

  assign tick     = (pre_cnt == PW'(CLKS_PER_TICK - 1));
  assign half_end = run && tick && (tick_cnt == HW'(TICKS_PER_HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_cnt  <= '0;
      tick_cnt <= '0;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (tick) begin
        tick_cnt <= (tick_cnt == HW'(TICKS_PER_HALF - 1)) ? '0 : tick_cnt + 1'b1;
      end
    end
  end

  // Independent cycle count since the current half began.
  logic [31:0] since_half;
  always_ff @(posedge clk) begin
    if (rst || !run || half_end) since_half <= '0;
    else                         since_half <= since_half + 1;
  end

  assert_half_length_R10: assert property (@(posedge clk) disable iff (rst)
    half_end |-> (since_half == 32'(HALF_LEN - 1)));

  assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !run |-> !half_end);
endmodule

// File: rtl/mtx_encoder.sv
module mtx_encoder #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              half_end,
  input  logic              stop,
  output logic              line_out,
  output logic              last_half
);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] shreg;
  logic [BW-1:0]     bits_left;
  logic              phase;   // 0 = first half, 1 = second half
  logic              line_q;

  assign last_half = phase && (bits_left == '0);
  assign line_out  = line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      bits_left <= '0;
      phase     <= 1'b0;
      line_q    <= 1'b0;
    end else if (stop) begin
      phase     <= 1'b0;
      line_q    <= 1'b0;
    end else if (load) begin
      shreg     <= load_byte;
      bits_left <= BW'(DATA_W - 1);
      phase     <= 1'b0;
      line_q    <= ~load_byte[DATA_W-1];
    end else if (half_end) begin
      if (!phase) begin
        phase  <= 1'b1;
        line_q <= shreg[DATA_W-1];
      end else begin
        phase     <= 1'b0;
        shreg     <= {shreg[DATA_W-2:0], 1'b0};
        bits_left <= bits_left - 1'b1;
        line_q    <= ~shreg[DATA_W-2];
      end
    end
  end

  assert_midbit_toggle_R1: assert property (@(posedge clk) disable iff (rst)
    (half_end && !phase && !load && !stop) |=> (line_out != $past(line_out)));

  assert_second_half_is_bit_R1: assert property (@(posedge clk) disable iff (rst)
    (half_end && !phase && !load && !stop) |=> (line_out == $past(shreg[DATA_W-1])));
endmodule

// File: rtl/mtx_sequencer.sv
module mtx_sequencer
  import mtx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              byte_end,
  output logic              in_ready,
  output logic              load,
  output logic [DATA_W-1:0] load_byte,
  output logic              stop,
  output logic              busy,
  output logic              frame_done
);
  localparam logic [63:0]       ALT64    = alt_pattern(DATA_W);
  localparam logic [DATA_W-1:0] PREAMBLE = ALT64[DATA_W-1:0];
  localparam logic [DATA_W-1:0] SENTINEL = '1;

  mtx_state_e        st, st_nx;
  logic [DATA_W-1:0] first_byte;
  logic              last_flag;
  logic              done_q;
  logic              start;
  logic              take_next;

  assign start     = (st == ST_IDLE) && in_valid && in_sop;
  assign in_ready  = (st == ST_IDLE) || ((st == ST_PAY) && byte_end && !last_flag);
  assign take_next = (st == ST_PAY) && byte_end && !last_flag && in_valid;
  assign busy      = (st != ST_IDLE);
  assign frame_done = done_q;

  always_comb begin
    st_nx     = st;
    load      = 1'b0;
    load_byte = in_data;
    stop      = 1'b0;
    unique case (st)
      ST_IDLE: if (start) begin
        load      = 1'b1;
        load_byte = PREAMBLE;
        st_nx     = ST_PRE;
      end
      ST_PRE: if (byte_end) begin
        load      = 1'b1;
        load_byte = first_byte;
        st_nx     = ST_PAY;
      end
      ST_PAY: if (byte_end) begin
        load = 1'b1;
        if (take_next) begin
          load_byte = in_data;
        end else begin
          load_byte = SENTINEL;
          st_nx     = ST_SENT;
        end
      end
      ST_SENT: if (byte_end) begin
        stop  = 1'b1;
        st_nx = ST_IDLE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      first_byte <= '0;
      last_flag  <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      st     <= st_nx;
      done_q <= (st == ST_SENT) && byte_end;
      if (start) begin
        first_byte <= in_data;
        last_flag  <= in_eop;
      end else if (take_next) begin
        last_flag  <= in_eop;
      end
    end
  end

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  assert_ready_at_boundary_R4: assert property (@(posedge clk) disable iff (rst)
    (in_ready && busy) |-> byte_end);

  assert_underflow_closes_R6: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_PAY) && byte_end && !in_valid) |=> (st == ST_SENT));

  assert_eop_closes_R5: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_PAY) && byte_end && last_flag) |=> (st == ST_SENT));
endmodule

// File: rtl/manch_frame_tx.sv
module manch_frame_tx #(
  parameter int DATA_W         = 8,
  parameter int CLKS_PER_TICK  = 125,
  parameter int TICKS_PER_HALF = 125
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              in_ready,
  output logic              line_out,
  output logic              busy,
  output logic              frame_done
);
  logic              half_end;
  logic              last_half;
  logic              byte_end;
  logic              load;
  logic              stop;
  logic [DATA_W-1:0] load_byte;

  assign byte_end = half_end && last_half;

  mtx_tick_gen #(
    .CLKS_PER_TICK (CLKS_PER_TICK),
    .TICKS_PER_HALF(TICKS_PER_HALF)
  ) u_tick (
    .clk     (clk),
    .rst     (rst),
    .run     (busy),
    .half_end(half_end)
  );

  mtx_sequencer #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .byte_end  (byte_end),
    .in_ready  (in_ready),
    .load      (load),
    .load_byte (load_byte),
    .stop      (stop),
    .busy      (busy),
    .frame_done(frame_done)
  );

  mtx_encoder #(.DATA_W(DATA_W)) u_enc (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_byte(load_byte),
    .half_end (half_end),
    .stop     (stop),
    .line_out (line_out),
    .last_half(last_half)
  );

  assert_idle_line_low_R7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !line_out);

  assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !busy);
endmodule

// File: tb/manch_frame_tx_bench.sv
module manch_frame_tx_bench;
  localparam int CPT = 2;
  localparam int TPH = 3;
  localparam int L   = CPT * TPH;
  localparam int NV  = 5;

  localparam logic [7:0] VB [NV][4] = '{
    '{8'h46, 8'h4F, 8'h4F, 8'h00},
    '{8'h80, 8'h00, 8'h00, 8'h00},
    '{8'h01, 8'hFF, 8'h00, 8'h00},
    '{8'h5A, 8'hC3, 8'h00, 8'h7E},
    '{8'h12, 8'h34, 8'h00, 8'h00}
  };
  localparam int VN [NV]     = '{3, 1, 2, 4, 2};
  localparam bit VEOP [NV]   = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic       in_ready, line_out, busy, frame_done;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int handshakes = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  manch_frame_tx #(.DATA_W(8), .CLKS_PER_TICK(CPT), .TICKS_PER_HALF(TPH)) u_manch_frame_tx (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_ready(in_ready), .line_out(line_out), .busy(busy),
    .frame_done(frame_done)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic wait_cyc(input int target);
    while (cyc != target) @(negedge clk);
  endtask

  task automatic feed(input int v, input int e0);
    wait_cyc(e0);
    for (int i = 1; i < VN[v]; i++) begin
      in_valid = 1'b1;
      in_sop   = 1'b0;
      in_data  = VB[v][i];
      in_eop   = VEOP[v] && (i == VN[v] - 1);
      while (!in_ready) @(negedge clk);
      handshakes++;
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_eop   = 1'b0;
  endtask

  task automatic watch(input int v, input int e0);
    int nbytes;
    logic [7:0] b;
    int bit_v;
    int exp;
    string tag;
    nbytes = VN[v] + 2;
    for (int k = 0; k < nbytes * 16; k++) begin
      int byte_i;
      int bit_i;
      byte_i = k / 16;
      bit_i  = 7 - ((k % 16) / 2);
      if (byte_i == 0)               b = 8'hAA;
      else if (byte_i == nbytes - 1) b = 8'hFF;
      else                           b = VB[v][byte_i - 1];
      bit_v = b[bit_i];
      exp   = (k % 2 == 0) ? (bit_v ^ 1) : bit_v;
      if (byte_i == 0)               tag = "R3";
      else if (byte_i == nbytes - 1) tag = VEOP[v] ? "R5" : "R6";
      else                           tag = (k % 2 == 0) ? "R1" : "R2";
      wait_cyc(e0 + k * L);
      check(tag, line_out, exp);
      if (k == 0) check("R7 busy high", busy, 1);
      wait_cyc(e0 + k * L + L - 1);
      check("R10 half end", line_out, exp);
    end
    wait_cyc(e0 + nbytes * 16 * L);
    check("R8 done pulse", frame_done, 1);
    check("R7 busy low", busy, 0);
    check("R7 line low", line_out, 0);
    @(negedge clk);
    check("R8 done width", frame_done, 0);
  endtask

  task automatic print_summary;
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    print_summary();
    $finish;
  end

  initial begin
    int e0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R7 reset line", line_out, 0);
    check("R7 reset busy", busy, 0);
    check("R8 reset done", frame_done, 0);
    check("R4 idle ready", in_ready, 1);

    // R9: beats without start flag are dropped
    in_valid = 1'b1; in_sop = 1'b0; in_data = 8'h55;
    repeat (20) begin
      @(negedge clk);
      check("R9 no frame busy", busy, 0);
      check("R9 no frame line", line_out, 0);
    end
    in_valid = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      handshakes = 0;
      in_valid = 1'b1; in_sop = 1'b1; in_data = VB[v][0];
      in_eop   = VEOP[v] && (VN[v] == 1);
      @(posedge clk);
      @(negedge clk);
      e0 = cyc;
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      fork
        feed(v, e0);
        watch(v, e0);
      join
      check("R4 handshakes", handshakes, VN[v] - 1);
      @(negedge clk);
    end

    // R4: during a frame ready stays low outside a byte boundary
    in_valid = 1'b1; in_sop = 1'b1; in_data = 8'h33; in_eop = 1'b1;
    @(posedge clk);
    @(negedge clk);
    e0 = cyc;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    wait_cyc(e0 + 3);
    check("R4 ready low mid-byte", in_ready, 0);
    wait_cyc(e0 + 3 * 16 * L);
    check("R8 short frame done", frame_done, 1);
    @(negedge clk);

    print_summary();
    $finish;
  end
endmodule